// File: doc/BRIEF.md
# Lock-step pipelined round-key generator

This block turns a stream of 256-bit padded user keys into the 33 round keys of a 32-round, 128-bit substitution-permutation cipher. It is a pipeline of one stage per round key. Every accepted key advances one stage per cycle, so that every block in flight carries its own key. Each stage derives four fresh 32-bit prekey words from the eight words produced by the two stages before it. It pushes the words through that stage's 4-bit S-box to form its round key, and passes the eight most recent words to the next stage.

The block sits beside a cipher datapath whose data runs one cycle behind the key. Stage j's round key is on the bus slot j for the whole cycle in which cipher round j works on the data of the same item. The last cipher round is split in two, using key 31 and then key 32, which is why there are 33 slots. The key may change on every accepted transfer, and no flush is needed.

The input side is valid/ready. A transfer happens on a clock edge where `in_valid` and `in_ready` are both high. Back-pressure comes from the cipher side through `pipe_stall`. While `pipe_stall` is high, `in_ready` is low and the whole pipeline, key and valid alike, freezes so that it stays aligned with the frozen datapath. A cycle that advances without a transfer inserts a bubble.

Top module: `rkey_pipe`

## Requirements
- R1: While reset is asserted, every bit of `rk_valid` and `rk_bus` is zero.
- R2: `in_ready` is the inverse of `pipe_stall` in every cycle.
- R3: On an edge with `pipe_stall` low, slot 0 takes `in_valid` as its valid flag and each slot j>0 takes the valid flag and key content of slot j-1. Slot j therefore holds the item accepted j+1 advancing edges earlier.
- R4: The prekeys of a key come from the user key and a recurrence:
  - w(-8+k) = `in_key[32k+31:32k]` for k = 0..7.
  - w(n) = rotate-left-by-11 of (w(n-8) ^ w(n-5) ^ w(n-3) ^ w(n-1) ^ 0x9E3779B9 ^ n) for n >= 0.
- R5: The round key in slot j is built nibble by nibble. Bits [4b+3:4b] equal S_s(x), with s = (3-j) mod 8 and x = {w(4j+3)[b], w(4j+2)[b], w(4j+1)[b], w(4j)[b]} (MSB first). S_s(x) is hex digit x, counted from the left starting at 0, of the string for box s:
  - S0 38F1A65BED42709C
  - S1 FC27905A1BE86D34
  - S2 86793CAFD1E40B52
  - S3 0FB8C963D124A75E
  - S4 1F83C0B6254A9E7D
  - S5 F52B4A9C03E8D671
  - S6 72C5846BE91FD3A0
  - S7 1DF0E82B74CA9356
- R6: Keys accepted on consecutive edges may all differ, and each slot shows the round key of its own item with no flush between them.
- R7: While `pipe_stall` is high, `rk_valid` and `rk_bus` hold their values and an asserted `in_valid` is not taken in.
- R8: An advancing edge with `in_valid` low puts a cleared valid flag into slot 0, and that bubble moves down the slots like an item.
- R9: The last slot (32) carries round key 32, built with box 3, for each item that reaches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A new key is offered |
| in_ready | output | 1 | The pipeline accepts a key this cycle |
| in_key | input | 256 | Padded user key |
| pipe_stall | input | 1 | Freeze request from the cipher datapath |
| rk_valid | output | 33 | Valid flag per slot, bit j for slot j |
| rk_bus | output | 4224 | Round keys, slot j at bits [128j+127:128j] |

## Verification
The bench builds the block with its default parameters: 33 slots, the 0x9E3779B9 constant and the 11-bit rotation. With these values every item runs the full recurrence through prekey 131 and visits all eight S-boxes, including the second use of box 3 in the final slot. A bench-side slot model, paired with a from-scratch recurrence, checks each valid slot on every cycle. It covers back-to-back key changes, bubbles, stalls with a key offered, a full drain and a reset in mid-flight.

// File: rtl/ksp_pkg.sv
package ksp_pkg;

  localparam int unsigned WORD_W    = 32;
  localparam int unsigned QUAD_N    = 4;
  localparam int unsigned WIN_N     = 2 * QUAD_N;
  localparam int unsigned RK_W      = WORD_W * QUAD_N;
  localparam int unsigned UKEY_W    = WORD_W * WIN_N;
  localparam int unsigned SBOX_N    = 8;

  typedef logic [WORD_W-1:0]        word_t;
  typedef logic [RK_W-1:0]          rkey_t;
  typedef word_t [QUAD_N-1:0]       quad_t;
  // index 0 holds the oldest word of the window
  typedef word_t [WIN_N-1:0]        win_t;

  // one 64-bit row per box, entry x at hex digit x from the left
  localparam logic [63:0] SBOX_ROWS [SBOX_N] = '{
    64'h38F1A65BED42709C,
    64'hFC27905A1BE86D34,
    64'h86793CAFD1E40B52,
    64'h0FB8C963D124A75E,
    64'h1F83C0B6254A9E7D,
    64'hF52B4A9C03E8D671,
    64'h72C5846BE91FD3A0,
    64'h1DF0E82B74CA9356
  };

  function automatic logic [3:0] sbox_lookup(input logic [2:0] sel, input logic [3:0] x);
    logic [63:0] row;
    row = SBOX_ROWS[sel];
    return row[63 - 4*int'(x) -: 4];
  endfunction

  function automatic word_t rotl(input word_t w, input int unsigned r);
    return (w << r) | (w >> (WORD_W - r));
  endfunction

endpackage

// File: rtl/ks_prekey_gen.sv
module ks_prekey_gen
  import ksp_pkg::*;
#(
  parameter int unsigned BASE = 0,
  parameter logic [31:0] PHI  = 32'h9E3779B9,
  parameter int unsigned ROT  = 11
) (
  input  win_t  win_i,
  output quad_t new_o
);

  localparam int unsigned EXT_N = WIN_N + QUAD_N;

  word_t ext_w [EXT_N];

  // new word n sits at ext_w[WIN_N+k]; its taps are n-8, n-5, n-3, n-1
  always_comb begin
    for (int k = 0; k < WIN_N; k++) ext_w[k] = win_i[k];
    for (int k = 0; k < QUAD_N; k++) begin
      ext_w[WIN_N+k] = rotl(ext_w[k] ^ ext_w[k+3] ^ ext_w[k+5] ^ ext_w[k+7]
                            ^ word_t'(PHI) ^ word_t'(BASE + k), ROT);
      new_o[k] = ext_w[WIN_N+k];
    end
  end

endmodule

// File: rtl/ks_rkey_sbox.sv
module ks_rkey_sbox
  import ksp_pkg::*;
#(
  parameter logic [2:0] SEL = 3'd3
) (
  input  quad_t w_i,
  output rkey_t rk_o
);

  for (genvar b = 0; b < WORD_W; b++) begin : g_nib
    assign rk_o[4*b +: 4] = sbox_lookup(SEL, {w_i[3][b], w_i[2][b], w_i[1][b], w_i[0][b]});
  end

endmodule

// File: rtl/ks_stage.sv
module ks_stage
  import ksp_pkg::*;
#(
  parameter int unsigned STAGE    = 0,
  parameter bit          KEEP_WIN = 1'b1,
  parameter logic [31:0] PHI      = 32'h9E3779B9,
  parameter int unsigned ROT      = 11
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv,
  input  logic  v_i,
  input  win_t  win_i,
  output logic  v_o,
  output rkey_t rk_o,
  output win_t  win_o
);

  // box index (3 - STAGE) mod 8
  localparam int unsigned SEL_I = (11 - (STAGE % SBOX_N)) % SBOX_N;
  localparam logic [2:0]  SEL   = SEL_I[2:0];

  quad_t fresh;
  rkey_t rk_nxt;

  ks_prekey_gen #(.BASE(QUAD_N * STAGE), .PHI(PHI), .ROT(ROT)) u_gen (
    .win_i (win_i),
    .new_o (fresh)
  );

  ks_rkey_sbox #(.SEL(SEL)) u_sbox (
    .w_i  (fresh),
    .rk_o (rk_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o  <= 1'b0;
      rk_o <= '0;
    end else if (adv) begin
      v_o  <= v_i;
      rk_o <= rk_nxt;
    end
  end

  if (KEEP_WIN) begin : g_win
    always_ff @(posedge clk) begin
      if (adv) win_o <= {fresh, win_i[WIN_N-1:QUAD_N]};
    end
  end else begin : g_nowin
    assign win_o = '0;
  end

endmodule

// File: rtl/rkey_pipe.sv
module rkey_pipe
  import ksp_pkg::*;
#(
  parameter int unsigned NRK = 33,
  parameter logic [31:0] PHI = 32'h9E3779B9,
  parameter int unsigned ROT = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [UKEY_W-1:0]     in_key,
  input  logic                  pipe_stall,
  output logic [NRK-1:0]        rk_valid,
  output logic [NRK*RK_W-1:0]   rk_bus
);

  localparam int unsigned LAST = NRK - 1;

  logic         adv;
  logic [NRK:0] v_chain;
  win_t         win_chain [NRK+1];

  assign adv          = !pipe_stall;
  assign in_ready     = adv;
  assign v_chain[0]   = in_valid;
  assign win_chain[0] = win_t'(in_key);

  for (genvar s = 0; s < NRK; s++) begin : g_st
    ks_stage #(
      .STAGE    (s),
      .KEEP_WIN (s < LAST),
      .PHI      (PHI),
      .ROT      (ROT)
    ) u_st (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (adv),
      .v_i   (v_chain[s]),
      .win_i (win_chain[s]),
      .v_o   (v_chain[s+1]),
      .rk_o  (rk_bus[s*RK_W +: RK_W]),
      .win_o (win_chain[s+1])
    );
  end

  assign rk_valid = v_chain[NRK:1];

endmodule

// File: rtl/rkey_pipe_chk.sv
module rkey_pipe_chk
  import ksp_pkg::*;
#(
  parameter int unsigned NRK = 33
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                pipe_stall,
  input logic [NRK-1:0]      rk_valid,
  input logic [NRK*RK_W-1:0] rk_bus
);

  AST_READY_VS_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready != pipe_stall);  // R2

  AST_FROZEN_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_stall |=> $stable(rk_valid) && $stable(rk_bus));  // R7

  AST_ENTRY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_stall |=> rk_valid[0] == $past(in_valid));  // R3

  AST_FLAG_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    !pipe_stall |=> rk_valid[NRK-1:1] == $past(rk_valid[NRK-2:0]));  // R3

  AST_BUBBLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (!pipe_stall && !in_valid) |=> !rk_valid[0]);  // R8

endmodule

bind rkey_pipe rkey_pipe_chk #(.NRK(NRK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .pipe_stall (pipe_stall),
  .rk_valid   (rk_valid),
  .rk_bus     (rk_bus)
);

// File: tb/test_rkey_pipe.sv
module test_rkey_pipe;

  localparam int CLK_PERIOD = 10;
  localparam int NRK        = 33;
  localparam int NKEYS      = 6;

  localparam logic [255:0] KEYS [NKEYS] = '{
    256'h0,
    {8{32'hFFFFFFFF}},
    {127'h0, 1'b1, 128'h00112233445566778899AABBCCDDEEFF},
    256'h0123456789ABCDEFFEDCBA98765432100F1E2D3C4B5A69788796A5B4C3D2E1F0,
    {8{32'hDEADBEEF}},
    256'h1
  };

  localparam logic [63:0] BOXES [8] = '{
    64'h38F1A65BED42709C, 64'hFC27905A1BE86D34, 64'h86793CAFD1E40B52, 64'h0FB8C963D124A75E,
    64'h1F83C0B6254A9E7D, 64'hF52B4A9C03E8D671, 64'h72C5846BE91FD3A0, 64'h1DF0E82B74CA9356
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_ready;
  logic [255:0]       in_key = '0;
  logic               pipe_stall = 1'b0;
  logic [NRK-1:0]     rk_valid;
  logic [NRK*128-1:0] rk_bus;

  int n_chk = 0;
  int n_bad = 0;

  logic         mv [NRK];
  logic [255:0] mk [NRK];

  always #(CLK_PERIOD/2) clk = ~clk;

  rkey_pipe i_rkey_pipe (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_key     (in_key),
    .pipe_stall (pipe_stall),
    .rk_valid   (rk_valid),
    .rk_bus     (rk_bus)
  );

  function automatic logic [127:0] ref_rk(input logic [255:0] key, input int j);
    logic [31:0]  w [140];
    logic [31:0]  t;
    logic [127:0] r;
    logic [3:0]   x;
    int           s;
    for (int n = 0; n < 8; n++) w[n] = key[32*n +: 32];
    for (int n = 8; n < 8 + 4*j + 4; n++) begin
      t = w[n-8] ^ w[n-5] ^ w[n-3] ^ w[n-1] ^ 32'h9E3779B9 ^ 32'(n-8);
      w[n] = {t[20:0], t[31:21]};
    end
    s = (35 - j) % 8;
    for (int b = 0; b < 32; b++) begin
      x = {w[4*j+11][b], w[4*j+10][b], w[4*j+9][b], w[4*j+8][b]};
      r[4*b +: 4] = 4'((BOXES[s] >> (60 - 4*int'(x))) & 64'hF);
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int j = 0; j < NRK; j++) begin
      mv[j] = 1'b0;
      mk[j] = '0;
    end
  endtask

  task automatic check_slots();
    logic [NRK-1:0] ev;
    for (int j = 0; j < NRK; j++) ev[j] = mv[j];
    chk(rk_valid == ev, "R3 R8 slot flags", 128'(rk_valid), 128'(ev));
    for (int j = 0; j < NRK; j++) begin
      if (mv[j]) begin
        if (j == NRK-1)
          chk(rk_bus[128*j +: 128] == ref_rk(mk[j], j), "R9 last slot key",
              rk_bus[128*j +: 128], ref_rk(mk[j], j));
        else
          chk(rk_bus[128*j +: 128] == ref_rk(mk[j], j), "R4 R5 R6 slot key",
              rk_bus[128*j +: 128], ref_rk(mk[j], j));
      end
    end
  endtask

  // drive after a falling edge, let one rising edge pass, check at the next falling edge
  task automatic step(input logic v, input logic [255:0] k, input logic st);
    logic [NRK*128-1:0] bus_before;
    logic [NRK-1:0]     val_before;
    in_valid   = v;
    in_key     = k;
    pipe_stall = st;
    #1;
    chk(in_ready == !st, "R2 ready", 128'(in_ready), 128'(!st));
    bus_before = rk_bus;
    val_before = rk_valid;
    @(posedge clk);
    if (!st) begin
      for (int j = NRK-1; j > 0; j--) begin
        mv[j] = mv[j-1];
        mk[j] = mk[j-1];
      end
      mv[0] = v;
      mk[0] = k;
    end
    @(negedge clk);
    if (st) begin
      chk(rk_valid == val_before, "R7 flags frozen", 128'(rk_valid), 128'(val_before));
      chk(rk_bus == bus_before, "R7 keys frozen", rk_bus[127:0], bus_before[127:0]);
    end
    check_slots();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rk_valid == '0, "R1 flags in reset", 128'(rk_valid), 128'h0);
    chk(rk_bus == '0, "R1 keys in reset", rk_bus[127:0], 128'h0);
    rst_n = 1'b1;

    // back-to-back differing keys from the table (R6)
    for (int i = 0; i < NKEYS; i++) step(1'b1, KEYS[i], 1'b0);

    // bubbles between items (R8)
    step(1'b0, '0, 1'b0);
    step(1'b0, KEYS[3], 1'b0);
    step(1'b1, KEYS[2], 1'b0);

    // stall with a key offered: nothing moves, key not taken (R7, R2)
    for (int i = 0; i < 3; i++) step(1'b1, {8{32'hA5A5A5A5}}, 1'b1);
    step(1'b1, KEYS[4], 1'b0);
    step(1'b0, '0, 1'b1);

    // drain so every item reaches the last slot (R9)
    for (int i = 0; i < NRK + 4; i++) step(1'b0, '0, 1'b0);

    // refill, then reset in mid-flight (R1)
    for (int i = 0; i < 5; i++) step(1'b1, KEYS[(i+1) % NKEYS], 1'b0);
    rst_n = 1'b0;
    #1;
    chk(rk_valid == '0, "R1 flags after mid reset", 128'(rk_valid), 128'h0);
    chk(rk_bus == '0, "R1 keys after mid reset", rk_bus[127:0], 128'h0);
    model_clear();
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, KEYS[1], 1'b0);
    step(1'b1, KEYS[1], 1'b0);

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule